// File: doc/BRIEF.md
# Chained Serial Register Port

This block is a four-wire serial slave port that lets a single controller chip select reach up to sixteen devices wired in a chain. Each device passes its serial input on to the next device through a forwarding output. On the way through, it rewrites the channel number in the first byte of the frame. A frame opens with a control byte and continues with an address byte and one or two data bytes. A device takes part in the frame only when it is the addressed channel or when the frame is marked as a broadcast. Behind the port sits a 64-entry by 8-bit register file. What the registers mean is left to the logic that uses them.

The port runs from a fast system clock. The serial clock, chip select and data inputs pass through a synchronizer and are handled on detected edges. Each half period of the serial clock must last at least four system clocks. The controller may use a short frame of 24 serial clocks or a long frame of 32. The block works out which one it received from where chip select rises, so no mode setting is needed. Register contents are undefined until they are written.

Top module: `daisy_spi_regs`

## Requirements
- R1: After reset, the read-data enable output is low and the forwarding output equals the serial data input.
- R2: Serial data is sampled on the rising serial clock edge, most significant bit first, while chip select is low. The first frame bit is the broadcast flag. The second bit is the read flag (1 = read, 0 = write). The third and fourth bits are reserved. Bits five to eight carry the 4-bit channel number, least significant bit first. The next eight bits are the register address, and the data byte follows.
- R3: The forwarding output repeats the serial input bit for bit, except that the channel number field carries the received number minus one, modulo 16. The broadcast, read and reserved bits and all later bits pass unchanged.
- R4: A device acts on a frame only when the channel number it receives is zero or the broadcast flag is set.
- R5: A targeted write stores the data byte once 24 bits have been received. In a 32-clock frame the last eight bits are ignored and alter no register.
- R6: A broadcast write is stored by every device in the chain. A broadcast frame with the read flag set writes nothing and drives no read data.
- R7: On a targeted read, the data bit is changed on the falling serial clock edge, starting after the 16th rising edge, most significant bit first. The register byte is sent twice, on clocks 17 to 24 and again on clocks 25 to 32, and a frame that ends after 24 clocks is a valid read.
- R8: Only the targeted device raises its read-data enable, and only during the read data phase. It lowers the enable after the 32nd rising edge or when chip select rises, and the enable is never high while chip select is inactive.
- R9: If chip select rises before the 24th bit has been received, the frame is abandoned and no register is written.
- R10: While chip select is high, serial clock and data activity changes no register and never enables the read data output.
- R11: Only the low six address bits select a register, so addresses that differ only in the top two bits reach the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Chip select, active low, shared along the chain |
| spi_sdi | input | 1 | Serial data in, from the controller or the previous device |
| spi_sdo | output | 1 | Serial read data; meaningful only while spi_sdo_oe is high |
| spi_sdo_oe | output | 1 | Drive enable for spi_sdo (low means high impedance) |
| spi_sdi_thru | output | 1 | Forwarded serial stream toward the next device |

## Verification
Two devices are chained, so each frame shows how the channel number is rewritten by two successive decrements. It also shows which of the two devices responds. Broadcast writes load every register first, and the checks that follow depend on known values. Directed frames cover ID zero and ID one reads and the short and long read lengths. They also cover trailing write bytes, broadcast reads, reserved bits set to ones, aliased addresses, frames cut off at 20 and 23 bits, and bus activity with chip select high. Constrained random frames mix channels, directions and lengths, including cut-off lengths. They separate a correct decrement from a wrong borrow and a long frame from a short one, and they catch a second device driving read data by mistake.

// File: rtl/daisy_spi_pkg.sv
package daisy_spi_pkg;
  // Serial frame layout (MSB first on the wire)
  localparam int BYTE_W    = 8;
  localparam int BCAST_POS = 7;   // first bit on the wire
  localparam int RD_POS    = 6;   // second bit on the wire

  typedef struct packed {
    logic bcast;
    logic rd;
  } ctrl_t;
endpackage

// File: rtl/dspi_sync_edge.sv
module dspi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic sdi_s
);
  // bit 2: sclk, bit 1: cs_n, bit 0: sdi
  logic [2:0] pipe [STAGES];
  logic       sclk_q;
  logic       act_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= 3'b010;
        else     pipe[g] <= {sclk_i, cs_n_i, sdi_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= 3'b010;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      sclk_q <= pipe[STAGES-1][2];
      act_q  <= ~pipe[STAGES-1][1];
    end
  end

  assign cs_act    = ~pipe[STAGES-1][1];
  assign sdi_s     = pipe[STAGES-1][0];
  assign sclk_rise = cs_act &  pipe[STAGES-1][2] & ~sclk_q;
  assign sclk_fall = cs_act & ~pipe[STAGES-1][2] &  sclk_q;
  assign cs_start  = cs_act & ~act_q;
  assign cs_end    = ~cs_act & act_q;
endmodule

// File: rtl/dspi_chain_fwd.sv
module dspi_chain_fwd #(
  parameter int CTRL_W = 8,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             bit_rise,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic             fwd_mask,
  output logic             id_zero
);
  localparam int ID_FIRST = CTRL_W - ID_W;
  localparam int ID_LAST  = CTRL_W - 1;

  logic borrow;
  logic borrow_nxt;
  logic in_id;

  assign in_id      = (int'(bit_idx) >= ID_FIRST) && (int'(bit_idx) <= ID_LAST);
  assign borrow_nxt = borrow & ~bit_val;

  always_ff @(posedge clk) begin
    if (rst || frame_start || frame_end) begin
      borrow   <= 1'b1;
      fwd_mask <= 1'b0;
      id_zero  <= 1'b0;
    end else if (bit_rise) begin
      if (int'(bit_idx) == ID_FIRST - 1) begin
        fwd_mask <= borrow;
      end
      if (in_id) begin
        borrow   <= borrow_nxt;
        fwd_mask <= (int'(bit_idx) == ID_LAST) ? 1'b0 : borrow_nxt;
        if (int'(bit_idx) == ID_LAST) id_zero <= borrow_nxt;
      end
    end
  end
endmodule

// File: rtl/dspi_regfile.sv
module dspi_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/daisy_spi_regs.sv
module daisy_spi_regs
  import daisy_spi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int ID_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe,
  output logic spi_sdi_thru
);
  localparam int CTRL_END = BYTE_W;
  localparam int ADDR_END = 2 * BYTE_W;
  localparam int DATA_END = ADDR_END + DATA_W;
  localparam int RD_END   = ADDR_END + 2 * DATA_W;
  localparam int CNT_W    = $clog2(RD_END + 1);
  localparam int BSEL_W   = $clog2(DATA_W);
  localparam int SH_W     = (DATA_W > BYTE_W) ? DATA_W : BYTE_W;

  logic              sclk_rise, sclk_fall, cs_act, cs_start, cs_end, sdi_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SH_W-1:0]   shreg;
  logic [SH_W-1:0]   byte_now;
  ctrl_t             ctrl_q;
  logic              ctrl_rd, ctrl_bcast;
  logic              fwd_mask, id_zero;
  logic              rd_active;
  logic              wr_en, rd_req;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata;
  logic [CNT_W-1:0]  rel_cnt;
  logic [BSEL_W-1:0] bit_sel;

  dspi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sclk_i   (spi_sclk),
    .cs_n_i   (spi_cs_n),
    .sdi_i    (spi_sdi),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_act   (cs_act),
    .cs_start (cs_start),
    .cs_end   (cs_end),
    .sdi_s    (sdi_s)
  );

  dspi_chain_fwd #(.CTRL_W(CTRL_END), .ID_W(ID_W), .CNT_W(CNT_W)) u_fwd (
    .clk        (clk),
    .rst        (rst),
    .frame_start(cs_start),
    .frame_end  (cs_end),
    .bit_rise   (sclk_rise),
    .bit_idx    (bit_cnt),
    .bit_val    (sdi_s),
    .fwd_mask   (fwd_mask),
    .id_zero    (id_zero)
  );

  // Zero-latency forwarding: the mask is held in a register and is
  // non-zero only on channel number bits that receive a borrow.
  assign spi_sdi_thru = spi_sdi ^ fwd_mask;

  assign byte_now   = {shreg[SH_W-2:0], sdi_s};
  assign ctrl_rd    = ctrl_q.rd;
  assign ctrl_bcast = ctrl_q.bcast;

  assign rd_req = sclk_rise && (int'(bit_cnt) == ADDR_END - 1) &&
                  ctrl_rd && !ctrl_bcast && id_zero;
  assign wr_en  = sclk_rise && (int'(bit_cnt) == DATA_END - 1) &&
                  !ctrl_rd && (ctrl_bcast || id_zero);

  dspi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk  (clk),
    .we   (wr_en),
    .waddr(addr_q),
    .wdata(byte_now[DATA_W-1:0]),
    .re   (rd_req),
    .raddr(byte_now[ADDR_W-1:0]),
    .rdata(rdata)
  );

  assign rel_cnt = bit_cnt - CNT_W'(ADDR_END);
  assign bit_sel = BSEL_W'(DATA_W - 1) - rel_cnt[BSEL_W-1:0];

  // Frame tracking
  always_ff @(posedge clk) begin
    if (rst || cs_end || cs_start) begin
      bit_cnt <= '0;
      shreg   <= '0;
      ctrl_q  <= '0;
      addr_q  <= '0;
    end else if (sclk_rise) begin
      shreg <= byte_now;
      if (int'(bit_cnt) != RD_END) bit_cnt <= bit_cnt + 1'b1;
      if (int'(bit_cnt) == CTRL_END - 1) begin
        ctrl_q.bcast <= byte_now[BCAST_POS];
        ctrl_q.rd    <= byte_now[RD_POS];
      end
      if (int'(bit_cnt) == ADDR_END - 1) addr_q <= byte_now[ADDR_W-1:0];
    end
  end

  // Read data output, changed on falling serial clock edges
  always_ff @(posedge clk) begin
    if (rst || cs_end) begin
      rd_active  <= 1'b0;
      spi_sdo_oe <= 1'b0;
      spi_sdo    <= 1'b1;
    end else begin
      if (rd_req) rd_active <= 1'b1;
      if (sclk_rise && rd_active && (int'(bit_cnt) == RD_END - 1)) begin
        rd_active  <= 1'b0;
        spi_sdo_oe <= 1'b0;
      end else if (sclk_fall && rd_active &&
                   (int'(bit_cnt) >= ADDR_END) && (int'(bit_cnt) < RD_END)) begin
        spi_sdo    <= rdata[bit_sel];
        spi_sdo_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/daisy_spi_regs_chk.sv
module daisy_spi_regs_chk (
  input logic clk,
  input logic rst,
  input logic spi_sdi,
  input logic spi_sdi_thru,
  input logic spi_sdo,
  input logic spi_sdo_oe,
  input logic cs_act,
  input logic sclk_rise,
  input logic wr_en,
  input logic ctrl_rd,
  input logic ctrl_bcast,
  input logic id_zero
);
  // R3: with no frame in progress, the stream is forwarded untouched
  a_r3_thru_idle: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> (spi_sdi_thru == spi_sdi));

  // R8: the output enable drops once chip select goes inactive
  a_r8_release_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_sdo_oe);

  // R8 / R6: only a targeted, non-broadcast read frame drives data
  a_r8_oe_targeted: assert property (@(posedge clk) disable iff (rst)
    spi_sdo_oe |-> (ctrl_rd && !ctrl_bcast && id_zero));

  // R7: the data bit never changes on a rising serial edge
  a_r7_sdo_stable_rise: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && spi_sdo_oe && $past(spi_sdo_oe)) |-> $stable(spi_sdo));

  // R9: writes happen only inside a frame, one cycle long
  a_r9_write_in_frame: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(cs_act));

  a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind daisy_spi_regs daisy_spi_regs_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .spi_sdi     (spi_sdi),
  .spi_sdi_thru(spi_sdi_thru),
  .spi_sdo     (spi_sdo),
  .spi_sdo_oe  (spi_sdo_oe),
  .cs_act      (cs_act),
  .sclk_rise   (sclk_rise),
  .wr_en       (wr_en),
  .ctrl_rd     (ctrl_rd),
  .ctrl_bcast  (ctrl_bcast),
  .id_zero     (id_zero)
);

// File: tb/daisy_spi_regs_bench.sv
`timescale 1ns/1ps
module daisy_spi_regs_bench;
  localparam int H = 5;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo0, oe0, thru0, sdo1, oe1, thru1;
  logic sdo_w;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m0 [64];
  logic [7:0] m1 [64];

  always #2.5 clk = ~clk;

  daisy_spi_regs u_daisy_spi_regs (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo0), .spi_sdo_oe(oe0), .spi_sdi_thru(thru0));

  daisy_spi_regs u_daisy_spi_regs_b (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(thru0),
    .spi_sdo(sdo1), .spi_sdo_oe(oe1), .spi_sdi_thru(thru1));

  assign sdo_w = oe0 ? sdo0 : (oe1 ? sdo1 : 1'b1);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: control byte layout
  function automatic logic [7:0] mk_ctrl(input bit bc, input bit rd,
                                         input logic [1:0] rsv, input logic [3:0] id);
    return {bc, rd, rsv, id[0], id[1], id[2], id[3]};
  endfunction

  task automatic do_op(input string tag, input bit bc, input bit rd,
                       input logic [1:0] rsv, input logic [3:0] id,
                       input logic [7:0] addr, input logic [7:0] data,
                       input int nbits);
    logic [31:0] strm, e_thru0, e_thru1, thru0_v, thru1_v, sdo_v, oe0_v, oe1_v;
    logic [31:0] e_sdo, e_oe0, e_oe1, mask;
    logic [7:0]  rbyte;
    bit          t0, t1, both;
    t0 = bc || (id == 4'd0);
    t1 = bc || (id == 4'd1);
    strm    = {mk_ctrl(bc, rd, rsv, id), addr, data, data ^ 8'hA5};
    e_thru0 = {mk_ctrl(bc, rd, rsv, id - 4'd1), strm[23:0]};
    e_thru1 = {mk_ctrl(bc, rd, rsv, id - 4'd2), strm[23:0]};
    thru0_v = '0; thru1_v = '0; sdo_v = '0; oe0_v = '0; oe1_v = '0;
    both = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = strm[31-i];
      repeat (H) @(negedge clk);
      thru0_v[31-i] = thru0;
      thru1_v[31-i] = thru1;
      sdo_v[31-i]   = sdo_w;
      oe0_v[31-i]   = oe0;
      oe1_v[31-i]   = oe1;
      if (oe0 && oe1) both = 1'b1;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
    mask = (nbits >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> nbits);
    chk((thru0_v & mask) == (e_thru0 & mask), {tag, " R3 dev0 forward"},
        64'(thru0_v & mask), 64'(e_thru0 & mask));
    chk((thru1_v & mask) == (e_thru1 & mask), {tag, " R3 dev1 forward"},
        64'(thru1_v & mask), 64'(e_thru1 & mask));
    chk(!both && !oe0 && !oe1, {tag, " R8 single driver, idle release"},
        64'({both, oe0, oe1}), 64'd0);
    e_sdo = 32'hFFFF_FFFF; e_oe0 = '0; e_oe1 = '0;
    rbyte = 8'h00;
    if (rd && !bc && (id == 4'd0 || id == 4'd1)) begin
      rbyte = (id == 4'd0) ? m0[addr[5:0]] : m1[addr[5:0]];
      for (int i = 16; i < 32; i++) begin
        if (i < nbits) begin
          e_sdo[31-i] = rbyte[7 - ((i - 16) % 8)];
          if (id == 4'd0) e_oe0[31-i] = 1'b1;
          else            e_oe1[31-i] = 1'b1;
        end
      end
    end
    chk((oe0_v & mask) == e_oe0 && (oe1_v & mask) == e_oe1,
        {tag, " R8 R4 R6 drive enable"}, {oe0_v & mask, oe1_v & mask}, {e_oe0, e_oe1});
    if (e_oe0 != 0 || e_oe1 != 0)
      chk((sdo_v & mask) == (e_sdo & mask), {tag, " R7 read data twice"},
          64'(sdo_v & mask), 64'(e_sdo & mask));
    // R5 R6 R9: model update, only on a complete data byte
    if (!rd && nbits >= 24) begin
      if (t0) m0[addr[5:0]] = data;
      if (t1) m1[addr[5:0]] = data;
    end
  endtask

  task automatic idle_toggle();
    bit bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sclk = ~sclk;
      sdi  = 1'($urandom);
      repeat (2) @(negedge clk);
      if (oe0 || oe1 || thru0 != sdi || thru1 != sdi) bad = 1'b1;
    end
    sclk = 1'b0;
    repeat (4 * H) @(negedge clk);
    chk(!bad, "R10 idle bus quiet", 64'(bad), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    chk(!oe0 && !oe1, "R1 enable low in reset", 64'({oe0, oe1}), 64'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    sdi = 1'b1; @(negedge clk);
    chk(thru0 == 1'b1 && thru1 == 1'b1, "R1 forward high", 64'({thru0, thru1}), 64'h3);
    sdi = 1'b0; @(negedge clk);
    chk(thru0 == 1'b0 && thru1 == 1'b0, "R1 forward low", 64'({thru0, thru1}), 64'h0);
    chk(!oe0 && !oe1, "R1 enable low after reset", 64'({oe0, oe1}), 64'd0);

    // R6: broadcast writes load every register of both devices
    for (int a = 0; a < 64; a++)
      do_op("R6 bcast init", 1'b1, 1'b0, 2'b00, 4'($urandom % 16), 8'(a),
            8'(a * 7 + 3), 24);

    // R2 R4 R7: directed reads
    do_op("R7 read dev0 long", 1'b0, 1'b1, 2'b00, 4'd0, 8'd5, 8'h00, 32);
    do_op("R7 read dev1 short", 1'b0, 1'b1, 2'b00, 4'd1, 8'd9, 8'h00, 24);
    do_op("R4 read id2 none", 1'b0, 1'b1, 2'b00, 4'd2, 8'd9, 8'h00, 32);
    do_op("R3 reserved ones", 1'b0, 1'b1, 2'b11, 4'd15, 8'd1, 8'h00, 32);
    // R5: targeted long write, trailing byte ignored
    do_op("R5 write dev1 long", 1'b0, 1'b0, 2'b00, 4'd1, 8'd20, 8'h5A, 32);
    do_op("R5 read back dev1", 1'b0, 1'b1, 2'b00, 4'd1, 8'd20, 8'h00, 32);
    do_op("R5 read dev0 untouched", 1'b0, 1'b1, 2'b00, 4'd0, 8'd20, 8'h00, 32);
    // R6: broadcast with read flag has no effect
    do_op("R6 bcast read", 1'b1, 1'b1, 2'b00, 4'd0, 8'd20, 8'hFF, 32);
    do_op("R6 read after bcast read", 1'b0, 1'b1, 2'b00, 4'd0, 8'd20, 8'h00, 24);
    // R9: cut-off writes
    do_op("R9 abort 20", 1'b0, 1'b0, 2'b00, 4'd0, 8'd3, 8'hC3, 20);
    do_op("R9 abort 23", 1'b0, 1'b0, 2'b00, 4'd0, 8'd3, 8'h3C, 23);
    do_op("R9 read after abort", 1'b0, 1'b1, 2'b00, 4'd0, 8'd3, 8'h00, 32);
    // R11: top address bits ignored
    do_op("R11 write alias", 1'b0, 1'b0, 2'b00, 4'd0, 8'hC7, 8'h96, 24);
    do_op("R11 read alias", 1'b0, 1'b1, 2'b00, 4'd0, 8'h07, 8'h00, 32);
    // R10: activity with chip select high
    idle_toggle();
    do_op("R10 read after idle", 1'b0, 1'b1, 2'b00, 4'd0, 8'h07, 8'h00, 32);
    do_op("R10 read dev1 after idle", 1'b0, 1'b1, 2'b00, 4'd1, 8'd20, 8'h00, 32);

    // Constrained random mix (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 70; k++) begin
      int sel, nb;
      sel = int'($urandom % 6);
      nb = (sel < 2) ? 24 : (sel < 4) ? 32 :
           (sel == 4) ? 8 + int'($urandom % 16) : 25 + int'($urandom % 7);
      do_op("R2 random", ($urandom % 5) == 0, 1'($urandom), 2'($urandom),
            4'($urandom % 4), 8'($urandom), 8'($urandom), nb);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule